// File: doc/BRIEF.md
# Image Sensor Power-Up and Calibration Sequencer

This block sits on the controller side of a column-ADC image sensor. It brings the sensor up after power is applied or after the sensor wakes from power-down. First it waits out a hold-off period measured in clock cycles. It then drives an active-low logic-reset pulse, which also makes the sensor run its per-column ADC offset calibration. Finally it waits for the sensor's active-low calibration-done pulse. Only after that pulse does it raise `ready_o`, which tells the readout controller that rows may be converted.

Software or the system controller can ask for a recalibration later, for example after a temperature drift, by pulsing `recal_req_i`. The sequencer then drives a separate active-low calibration-start pulse. It never fires that pulse while the readout controller reports a row in flight (`rd_busy_i` high). The request is held until the readout controller goes idle.

Every request, whether a logic reset or a calibration start, opens a response window. If the sensor does not answer inside that window, the sequencer raises `timeout_o` and parks with `ready_o` low until the next recalibration request.

Top module: `snsr_cal_seq`

## Requirements
- R1: While reset is asserted and after it is released with `pwr_ok_i` low, `lrst_no` and `calstrt_no` are 1 (inactive) and `ready_o` and `timeout_o` are 0.
- R2: After `pwr_ok_i` is first sampled high, `lrst_no` stays 1 for exactly HOLD_CYC = CLK_MHZ*HOLDOFF_US cycles (66 at the defaults) and falls in the next cycle.
- R3: The logic-reset pulse is exactly 2 cycles low. No calibration-start pulse follows it, and the two pulses are never low together.
- R4: Number cycles from 0 at the first low cycle of a request pulse. A calibration-done pulse (`cal_done_ni` low) whose first low cycle c satisfies 2 <= c <= WD-1 sets `ready_o` in cycle c+1. Here WD = DONE_LIMIT + DONE_MARGIN, which is 120 at the defaults.
- R5: If no done pulse starts by cycle WD-1, `timeout_o` rises in cycle WD with `ready_o` still 0. A done pulse that arrives after that has no effect.
- R6: With `rd_busy_i` low, a `recal_req_i` pulse sampled in the ready or timed-out state drives `calstrt_no` low in the next cycle for exactly 2 cycles. In that same first cycle `ready_o` and `timeout_o` fall.
- R7: While `rd_busy_i` is high, a recalibration request produces no pulse and leaves `ready_o` and `timeout_o` unchanged. The request is held, and the pulse starts one cycle after `rd_busy_i` is sampled low.
- R8: When `pwr_ok_i` is sampled low, all four outputs are inactive in the next cycle and any held request is dropped. The next power-up repeats the full hold-off and logic reset.
- R9: Recalibration requests seen before the logic-reset pulse starts are absorbed by that reset and cause no later calibration-start pulse.
- R10: A request seen while a calibration is in flight is held. It fires a calibration-start pulse one cycle after `ready_o` rises, and `ready_o` is high for that single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sensor system clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_ok_i | input | 1 | High while the sensor is powered and awake |
| recal_req_i | input | 1 | One-cycle recalibration request |
| rd_busy_i | input | 1 | High while the readout controller has a row in progress |
| cal_done_ni | input | 1 | Active-low calibration-done pulse from the sensor |
| lrst_no | output | 1 | Active-low logic-reset pulse to the sensor |
| calstrt_no | output | 1 | Active-low calibration-start pulse to the sensor |
| ready_o | output | 1 | Calibration finished; readout may proceed |
| timeout_o | output | 1 | Last request got no done pulse within the window |

## Verification
The bench builds the sequencer with CLK_MHZ=10, HOLDOFF_US=1, DONE_LIMIT=20 and DONE_MARGIN=4. This gives a 10-cycle hold-off and a 24-cycle response window. Each bring-up and each timeout therefore takes only a few dozen cycles. That makes room for many randomized recalibrations, with done delays on both sides of the window edge and busy stretches of random length. The short window also lets directed cases hit cycle 2, cycle WD-1 and cycle WD exactly. They cover a request queued in flight and power loss both in the wait phase and with a held request.

// File: rtl/scs_pkg.sv
package scs_pkg;

  // Sequencer states
  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,  // sensor unpowered or asleep
    ST_HOLD = 3'd1,  // power-up hold-off running
    ST_LRST = 3'd2,  // logic-reset pulse low
    ST_CAL  = 3'd3,  // calibration-start pulse low
    ST_WAIT = 3'd4,  // waiting for calibration-done
    ST_RDY  = 3'd5,  // calibrated, readout allowed
    ST_FAIL = 3'd6   // no answer inside window
  } scs_state_e;

  // Width of every request pulse sent to the sensor, fixed by its protocol
  localparam int unsigned PULSE_CYC = 2;

  // Depth of the reset release synchronizer
  localparam int unsigned RST_STAGES = 2;

endpackage

// File: rtl/scs_rst_sync.sv
module scs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  // Shift ones in from the bottom once reset is released
  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/scs_cyc_timer.sv
module scs_cyc_timer #(
  parameter int unsigned LIMIT = 66
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic hit_o
);

  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  // Clear has priority; the count stops at LAST
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = clr_i | en_i;
    if (clr_i) begin
      cnt_d = '0;
    end else if (en_i && (cnt_q != LAST)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign hit_o = en_i && (cnt_q == LAST);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R2

endmodule

// File: rtl/scs_req_queue.sv
module scs_req_queue (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic drop_i,
  input  logic req_i,
  output logic pend_o
);

  logic pend_q;
  logic pend_d;

  // A request is held until it is served, absorbed or flushed
  always_comb begin
    if (flush_i || drop_i) begin
      pend_d = 1'b0;
    end else begin
      pend_d = pend_q | req_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  AST_PEND_FROM_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(req_i)); // R7

  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !pend_q); // R8

endmodule

// File: rtl/snsr_cal_seq.sv
module snsr_cal_seq
  import scs_pkg::*;
#(
  parameter int unsigned CLK_MHZ     = 66,
  parameter int unsigned HOLDOFF_US  = 1,
  parameter int unsigned DONE_LIMIT  = 112,
  parameter int unsigned DONE_MARGIN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_ok_i,
  input  logic recal_req_i,
  input  logic rd_busy_i,
  input  logic cal_done_ni,
  output logic lrst_no,
  output logic calstrt_no,
  output logic ready_o,
  output logic timeout_o
);

  localparam int unsigned HOLD_CYC = CLK_MHZ * HOLDOFF_US;
  localparam int unsigned WD_CYC   = DONE_LIMIT + DONE_MARGIN;

  logic       rst_n_s;
  scs_state_e state_q;
  scs_state_e state_d;
  logic       hold_hit;
  logic       pw_hit;
  logic       wd_hit;
  logic       in_hold;
  logic       in_pulse;
  logic       in_flight;
  logic       pend;
  logic       take;
  logic       enter_lrst;
  logic       lrst_q;
  logic       calstrt_q;
  logic       rdy_q;
  logic       tmo_q;

  scs_rst_sync #(
    .STAGES (RST_STAGES)
  ) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  assign in_hold   = (state_q == ST_HOLD);
  assign in_pulse  = (state_q == ST_LRST) || (state_q == ST_CAL);
  assign in_flight = in_pulse || (state_q == ST_WAIT);

  // Power-up hold-off
  scs_cyc_timer #(
    .LIMIT (HOLD_CYC)
  ) u_hold_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .clr_i  (!in_hold),
    .en_i   (in_hold),
    .hit_o  (hold_hit)
  );

  // Request pulse width
  scs_cyc_timer #(
    .LIMIT (PULSE_CYC)
  ) u_pulse_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .clr_i  (!in_pulse),
    .en_i   (in_pulse),
    .hit_o  (pw_hit)
  );

  // Response window, counted from the first low cycle of a request
  scs_cyc_timer #(
    .LIMIT (WD_CYC)
  ) u_wd_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .clr_i  (!in_flight),
    .en_i   (in_flight),
    .hit_o  (wd_hit)
  );

  assign take = pwr_ok_i && !rd_busy_i && (pend || recal_req_i) &&
                ((state_q == ST_RDY) || (state_q == ST_FAIL));

  assign enter_lrst = (state_d == ST_LRST) && (state_q != ST_LRST);

  scs_req_queue u_req_queue (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .flush_i (!pwr_ok_i),
    .drop_i  (enter_lrst || take),
    .req_i   (recal_req_i),
    .pend_o  (pend)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    if (!pwr_ok_i) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:  state_d = ST_HOLD;
        ST_HOLD: if (hold_hit) state_d = ST_LRST;
        ST_LRST: if (pw_hit)   state_d = ST_WAIT;
        ST_CAL:  if (pw_hit)   state_d = ST_WAIT;
        ST_WAIT: begin
          if (!cal_done_ni) begin
            state_d = ST_RDY;
          end else if (wd_hit) begin
            state_d = ST_FAIL;
          end
        end
        ST_RDY, ST_FAIL: if (take) state_d = ST_CAL;
        default: state_d = ST_OFF;
      endcase
    end
  end

  // State and registered outputs decoded from the next state
  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q   <= ST_OFF;
      lrst_q    <= 1'b1;
      calstrt_q <= 1'b1;
      rdy_q     <= 1'b0;
      tmo_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      lrst_q    <= (state_d != ST_LRST);
      calstrt_q <= (state_d != ST_CAL);
      rdy_q     <= (state_d == ST_RDY);
      tmo_q     <= (state_d == ST_FAIL);
    end
  end

  assign lrst_no    = lrst_q;
  assign calstrt_no = calstrt_q;
  assign ready_o    = rdy_q;
  assign timeout_o  = tmo_q;

  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    lrst_q || calstrt_q); // R3

  AST_LRST_MIN_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    $fell(lrst_q) |=> !lrst_q); // R3

  AST_LRST_MAX_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (!lrst_q && $past(!lrst_q)) |=> lrst_q); // R3

  AST_CAL_MIN_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    $fell(calstrt_q) |=> !calstrt_q); // R6

  AST_CAL_MAX_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (!calstrt_q && $past(!calstrt_q)) |=> calstrt_q); // R6

  AST_READY_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    $rose(rdy_q) |-> $past(!cal_done_ni)); // R4

  AST_READY_TIMEOUT_APART: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !(rdy_q && tmo_q)); // R5

  AST_BUSY_BLOCKS_CAL: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (rd_busy_i && calstrt_q) |=> calstrt_q); // R7

  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !pwr_ok_i |=> (lrst_q && calstrt_q && !rdy_q && !tmo_q)); // R8

endmodule

// File: tb/snsr_cal_seq_tb_top.sv
module snsr_cal_seq_tb_top;

  localparam int CLK_MHZ     = 10;
  localparam int HOLDOFF_US  = 1;
  localparam int DONE_LIMIT  = 20;
  localparam int DONE_MARGIN = 4;
  localparam int H  = CLK_MHZ * HOLDOFF_US;
  localparam int WD = DONE_LIMIT + DONE_MARGIN;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic pwr_ok;
  logic recal_req;
  logic rd_busy;
  logic cal_done_n;
  logic lrst_n;
  logic calstrt_n;
  logic ready;
  logic timeout;

  int n_chk = 0;
  int n_bad = 0;

  snsr_cal_seq #(
    .CLK_MHZ     (CLK_MHZ),
    .HOLDOFF_US  (HOLDOFF_US),
    .DONE_LIMIT  (DONE_LIMIT),
    .DONE_MARGIN (DONE_MARGIN)
  ) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pwr_ok_i    (pwr_ok),
    .recal_req_i (recal_req),
    .rd_busy_i   (rd_busy),
    .cal_done_ni (cal_done_n),
    .lrst_no     (lrst_n),
    .calstrt_no  (calstrt_n),
    .ready_o     (ready),
    .timeout_o   (timeout)
  );

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // Done pulse starting at cycle d is accepted only inside the window
  function automatic bit accept_fn(input int d);
    return (d >= 2) && (d <= WD - 1);
  endfunction

  task automatic quiet_chk(input string tag);
    chk(int'(lrst_n), 1, tag);
    chk(int'(calstrt_n), 1, tag);
    chk(int'(ready), 0, tag);
    chk(int'(timeout), 0, tag);
  endtask

  // Returns at cycle 2 of the logic-reset request
  task automatic power_up(input bit inject);
    pwr_ok = 1'b1;
    for (int k = 0; k < H; k++) begin
      if (inject && (k == 3)) recal_req = 1'b1;
      step();
      recal_req = 1'b0;
      chk(int'(lrst_n), 1, "R2 hold-off keeps reset high");
    end
    step();
    chk(int'(lrst_n), 0, "R2 reset falls after hold-off");
    step();
    chk(int'(lrst_n), 0, "R3 reset second low cycle");
    step();
    chk(int'(lrst_n), 1, "R3 reset width two cycles");
    chk(int'(calstrt_n), 1, "R3 no calibration-start after reset");
  endtask

  // Returns at cycle 2 of the calibration-start request
  task automatic issue_recal(input int busy_len);
    logic r0;
    logic t0;
    r0 = ready;
    t0 = timeout;
    recal_req = 1'b1;
    rd_busy = (busy_len > 0);
    step();
    recal_req = 1'b0;
    for (int i = 0; i < busy_len; i++) begin
      chk(int'(calstrt_n), 1, "R7 no pulse while busy");
      chk(int'(ready), int'(r0), "R7 ready unchanged while busy");
      chk(int'(timeout), int'(t0), "R7 timeout unchanged while busy");
      if (i == busy_len - 1) rd_busy = 1'b0;
      step();
    end
    chk(int'(calstrt_n), 0, "R6 calibration-start falls");
    chk(int'(ready), 0, "R6 ready drops with request");
    chk(int'(timeout), 0, "R6 timeout clears with request");
    step();
    chk(int'(calstrt_n), 0, "R6 calibration-start second low cycle");
    step();
    chk(int'(calstrt_n), 1, "R6 calibration-start width two cycles");
  endtask

  task automatic respond(input int d, input int c_now);
    bit acc;
    acc = accept_fn(d);
    step(d - c_now);
    cal_done_n = 1'b0;
    step();
    chk(int'(ready), int'(acc), "R4 ready after done in window");
    chk(int'(timeout), int'(!acc), "R5 timeout when done is late");
    step();
    cal_done_n = 1'b1;
    step();
    chk(int'(ready), int'(acc), "R5 late done has no effect");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    pwr_ok = 1'b0;
    recal_req = 1'b0;
    rd_busy = 1'b0;
    cal_done_n = 1'b1;
    step(3);
    quiet_chk("R1 outputs during reset");
    rst_n = 1'b1;
    step(4);
    quiet_chk("R1 outputs after reset release");

    // Bring-up with a request during hold-off, done at earliest cycle
    power_up(1'b1);
    respond(2, 2);
    for (int i = 0; i < 5; i++) begin
      step();
      chk(int'(calstrt_n), 1, "R9 request before reset absorbed");
    end

    // Timeout exactly at window edge
    issue_recal(0);
    step(WD - 3);
    chk(int'(timeout), 0, "R5 no timeout at cycle WD-1");
    step();
    chk(int'(timeout), 1, "R5 timeout at cycle WD");
    chk(int'(ready), 0, "R5 ready stays low on timeout");
    cal_done_n = 1'b0;
    step(2);
    cal_done_n = 1'b1;
    step();
    chk(int'(ready), 0, "R5 done after timeout ignored");
    chk(int'(timeout), 1, "R5 timeout held");

    // Recover from timeout with busy, done at last window cycle
    issue_recal(3);
    respond(WD - 1, 2);
    issue_recal(0);
    respond(WD, 2);

    // Request queued while calibration in flight
    issue_recal(0);
    step(2);
    recal_req = 1'b1;
    step();
    recal_req = 1'b0;
    step(2);
    cal_done_n = 1'b0;
    step();
    chk(int'(ready), 1, "R10 ready rises before queued request");
    step();
    cal_done_n = 1'b1;
    chk(int'(calstrt_n), 0, "R10 queued request fires next cycle");
    chk(int'(ready), 0, "R10 ready high one cycle only");
    step(2);
    respond(5, 2);

    // Power loss with a held request
    rd_busy = 1'b1;
    recal_req = 1'b1;
    step();
    recal_req = 1'b0;
    pwr_ok = 1'b0;
    step();
    quiet_chk("R8 outputs inactive after power loss");
    rd_busy = 1'b0;
    step(2);
    power_up(1'b0);
    respond(6, 2);
    for (int i = 0; i < 5; i++) begin
      step();
      chk(int'(calstrt_n), 1, "R8 held request dropped on power loss");
    end

    // Power loss while waiting for done
    issue_recal(0);
    step(3);
    pwr_ok = 1'b0;
    step();
    quiet_chk("R8 outputs inactive mid-wait");
    step();
    power_up(1'b0);
    respond(3, 2);

    // Randomized recalibrations
    for (int it = 0; it < 30; it++) begin
      int bl;
      int dl;
      bl = $urandom_range(0, 4);
      dl = $urandom_range(2, WD + 3);
      issue_recal(bl);
      respond(dl, 2);
      step($urandom_range(0, 3));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule